// File: doc/BRIEF.md
# Unslotted CSMA-CA Transmit Sequencer

This block runs the channel-access and transmit sequence for one outgoing frame of a low-rate wireless MAC. A one-cycle command pulse starts it. It first waits a fixed MAC delay. It then requests clear-channel assessments, each preceded by a random number of backoff periods, and the backoff exponent grows after every busy assessment. Once the channel is clear it requests transmission. If the frame asked for an acknowledgement, it opens a listening window and checks the returned sequence number. When an attempt fails, it starts a fresh attempt until the frame retry budget is used up. Every run ends with a one-cycle completion pulse that carries a 3-bit outcome code and a flag saying whether the radio should stay in receive.

The radio front end, the frame buffer and the ACK parser are outside the block. They talk to it through one-cycle strobes. All delays are counted in microsecond ticks from a shared timebase and not in clock cycles. Configuration and the outgoing frame's ACK-request flag and sequence number are captured when the command is accepted. The block has no streaming data path: every pin is a plain control or status signal, so no valid/ready back-pressure applies.

Top module: `csma_tx_ctrl`

## Requirements
- R1: After reset the block is idle: busy, done, CCA request, transmit request and ACK-listen outputs are 0, and the status is 0.
- R2: After an accepted command the block waits MAC_DELAY_US ticks, then a backoff of r×BO_PERIOD_US ticks with r drawn from 0..2^BE−1 (BE starts at the configured minimum), then pulses the CCA request. All waits advance only on cycles where the microsecond tick is high.
- R3: A clear CCA result leads to a transmit request. A busy result raises BE by one, never past the configured maximum, and starts another backoff. After max_cca+1 busy results the run ends with status 2.
- R4: A CCA retry setting of 7 turns CSMA off. The transmit request follows the MAC delay directly, no CCA request is made, and the BE fields are not checked.
- R5: If the outgoing frame's ACK-request flag (bit 5 of its first frame-control byte) is 0, the run ends with status 0 after the transmit-done strobe. The rx-after flag then equals the turnaround setting.
- R6: With the flag set, the block listens for up to ACK_WAIT_US ticks. An ACK whose sequence number matches ends the run: with frame-pending clear, status 0 and rx-after equal to turnaround; with frame-pending set, status 1 and rx-after 1.
- R7: A window that expires, or an ACK with a mismatched sequence number, fails the attempt. A new attempt restarts with the CCA count at 0 and BE at the minimum. The run ends with status 3 once max_frame transmissions have failed.
- R8: A command whose configuration is invalid ends at once with status 4 and no CCA or transmit request. Invalid means any of: CCA retry setting 5 < n < 7; frame retry setting 0; or, with CSMA on, maximum BE outside 3..8 or minimum BE above maximum BE.
- R9: Every outcome gives exactly one one-cycle done pulse. The status (0 success, 1 success with data pending, 2 channel-access failure, 3 no ACK, 4 configuration error) and rx-after are valid in that cycle. Done, CCA request and transmit request are never high together.
- R10: Abort stops a running sequence within one cycle, with no done pulse and no later requests. Abort also wins over a command in the same cycle.
- R11: CCA-result, transmit-done and ACK strobes that arrive while the block is not waiting for them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| us_tick_i | input | 1 | One-cycle microsecond timebase strobe |
| start_i | input | 1 | Command pulse that starts a transmit sequence |
| abort_i | input | 1 | Stops any running sequence |
| cfg_max_cca_i | input | 3 | CCA retry limit 0..5, 7 disables CSMA |
| cfg_max_frame_i | input | 4 | Total transmissions allowed, 1..15 |
| cfg_min_be_i | input | 4 | Initial backoff exponent |
| cfg_max_be_i | input | 4 | Backoff exponent ceiling, 3..8 |
| cfg_turnaround_i | input | 1 | Stay in receive after a successful run |
| frm_ack_req_i | input | 1 | ACK-request flag of the outgoing frame |
| frm_seq_i | input | 8 | Sequence number of the outgoing frame |
| cca_done_i | input | 1 | CCA result strobe |
| cca_clear_i | input | 1 | CCA result, 1 means channel idle |
| tx_done_i | input | 1 | Frame transmission finished strobe |
| ack_valid_i | input | 1 | Received ACK strobe |
| ack_seq_i | input | 8 | Sequence number of the received ACK |
| ack_pend_i | input | 1 | Frame-pending bit of the received ACK |
| cca_start_o | output | 1 | Pulse requesting a CCA |
| tx_start_o | output | 1 | Pulse requesting transmission |
| ack_listen_o | output | 1 | High while the ACK window is open |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |
| status_o | output | 3 | Outcome code, valid with done |
| rx_after_o | output | 1 | Radio should enter receive, valid with done |

## Verification
The hardest conditions to reach from the ports are the retry paths. In these the CCA count and backoff exponent must reset, a late or wrong ACK must count as a failure, and random backoff hides the exact cycle of each request. The stimulus therefore reacts to the block's own CCA and transmit request pulses with scripted busy/clear answers, delayed ACKs and mismatched sequence numbers, and counts the requests per run. Exact timing is checked with a minimum exponent of 0, which forces a zero backoff. Bounded timing is checked over repeated runs at a fixed exponent. A stalled tick shows that waits follow the timebase only.

// File: rtl/csma_pkg.sv
package csma_pkg;
  localparam int CCA_CNT_W  = 3;
  localparam int FRM_CNT_W  = 4;
  localparam int BE_W       = 4;
  localparam int BE_FLOOR   = 3;
  localparam int BE_CEIL    = 8;
  localparam int RND_W      = BE_CEIL;
  localparam logic [CCA_CNT_W-1:0] CCA_OFF_CODE = 3'd7;
  localparam logic [CCA_CNT_W-1:0] CCA_MAX_OK   = 3'd5;

  typedef enum logic [2:0] {
    ST_IDLE, ST_MACD, ST_BOFF, ST_CCA, ST_TX, ST_ACK
  } csma_state_e;

  localparam logic [2:0] STS_OK        = 3'd0;
  localparam logic [2:0] STS_PEND      = 3'd1;
  localparam logic [2:0] STS_CSMA_FAIL = 3'd2;
  localparam logic [2:0] STS_NOACK     = 3'd3;
  localparam logic [2:0] STS_CFG_ERR   = 3'd4;
endpackage

// File: rtl/csma_lfsr.sv
module csma_lfsr #(
  parameter int          W     = 16,
  parameter int          OUT_W = 8,
  parameter logic [W-1:0] TAPS = 16'hD008,
  parameter logic [W-1:0] SEED = 16'hACE1
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [OUT_W-1:0] rnd_o
);
  logic [W-1:0] q;
  logic         fb;

  assign fb    = ^(q & TAPS);
  assign rnd_o = q[OUT_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= SEED;
    else        q <= {q[W-2:0], fb};
  end

  // R2
  lfsr_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n) q != '0);
endmodule

// File: rtl/csma_tick_timer.sv
module csma_tick_timer #(
  parameter int W = 20
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick_i,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         expired_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     cnt_q <= '0;
    else if (load_i)                cnt_q <= val_i;
    else if (tick_i && cnt_q != '0) cnt_q <= cnt_q - W'(1);
  end

  assign expired_o = (cnt_q == '0);

  // R2
  tmr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && !tick_i) |=> $stable(cnt_q));
endmodule

// File: rtl/csma_seq.sv
module csma_seq
  import csma_pkg::*;
#(
  parameter int MAC_DELAY_US = 192,
  parameter int BO_PERIOD_US = 320,
  parameter int ACK_WAIT_US  = 864,
  parameter int TIMER_W      = 20,
  parameter int SEQ_W        = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start_i,
  input  logic                 abort_i,
  input  logic [CCA_CNT_W-1:0] cfg_max_cca_i,
  input  logic [FRM_CNT_W-1:0] cfg_max_frame_i,
  input  logic [BE_W-1:0]      cfg_min_be_i,
  input  logic [BE_W-1:0]      cfg_max_be_i,
  input  logic                 cfg_turnaround_i,
  input  logic                 frm_ack_req_i,
  input  logic [SEQ_W-1:0]     frm_seq_i,
  input  logic                 cca_done_i,
  input  logic                 cca_clear_i,
  input  logic                 tx_done_i,
  input  logic                 ack_valid_i,
  input  logic [SEQ_W-1:0]     ack_seq_i,
  input  logic                 ack_pend_i,
  input  logic [RND_W-1:0]     rnd_i,
  input  logic                 tmr_expired_i,
  output logic                 tmr_load_o,
  output logic [TIMER_W-1:0]   tmr_val_o,
  output logic                 cca_start_o,
  output logic                 tx_start_o,
  output logic                 ack_listen_o,
  output logic                 busy_o,
  output logic                 done_o,
  output logic [2:0]           status_o,
  output logic                 rx_after_o
);
  csma_state_e state_q, state_d;
  logic [CCA_CNT_W-1:0] nb_q, nb_d, mcca_q;
  logic [FRM_CNT_W-1:0] tries_q, tries_d, mfr_q;
  logic [BE_W-1:0]      be_q, be_d, minbe_q, maxbe_q, be_up;
  logic                 turn_q, ackreq_q, latch;
  logic [SEQ_W-1:0]     seq_q;
  logic                 cca_q, cca_d, tx_q, tx_d, done_q, done_d, rx_q, rx_d;
  logic [2:0]           status_q, status_d;
  logic [RND_W-1:0]     rnd_first, rnd_next;
  logic                 csma_off, ack_match;

  function automatic logic [RND_W-1:0] limit_rnd(input logic [RND_W-1:0] r,
                                                 input logic [BE_W-1:0]  e);
    logic [RND_W-1:0] m;
    for (int i = 0; i < RND_W; i++) m[i] = (BE_W'(i) < e);
    return r & m;
  endfunction

  function automatic logic cfg_bad(input logic [CCA_CNT_W-1:0] c,
                                   input logic [FRM_CNT_W-1:0] f,
                                   input logic [BE_W-1:0]      lo,
                                   input logic [BE_W-1:0]      hi);
    logic bad;
    bad = (f == '0) || (c > CCA_MAX_OK && c != CCA_OFF_CODE);
    if (c != CCA_OFF_CODE)
      bad = bad || (hi < BE_W'(BE_FLOOR)) || (hi > BE_W'(BE_CEIL)) || (lo > hi);
    return bad;
  endfunction

  assign csma_off  = (mcca_q == CCA_OFF_CODE);
  assign be_up     = (be_q < maxbe_q) ? be_q + BE_W'(1) : be_q;
  assign rnd_first = limit_rnd(rnd_i, minbe_q);
  assign rnd_next  = limit_rnd(rnd_i, be_up);
  assign ack_match = ack_valid_i && (ack_seq_i == seq_q);

  always_comb begin
    state_d    = state_q;
    nb_d       = nb_q;
    be_d       = be_q;
    tries_d    = tries_q;
    cca_d      = 1'b0;
    tx_d       = 1'b0;
    done_d     = 1'b0;
    status_d   = status_q;
    rx_d       = rx_q;
    tmr_load_o = 1'b0;
    tmr_val_o  = '0;
    latch      = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          if (cfg_bad(cfg_max_cca_i, cfg_max_frame_i, cfg_min_be_i, cfg_max_be_i)) begin
            done_d   = 1'b1;
            status_d = STS_CFG_ERR;
            rx_d     = 1'b0;
          end else begin
            latch      = 1'b1;
            nb_d       = '0;
            be_d       = cfg_min_be_i;
            tries_d    = '0;
            tmr_load_o = 1'b1;
            tmr_val_o  = TIMER_W'(MAC_DELAY_US);
            state_d    = ST_MACD;
          end
        end
      end
      ST_MACD: begin
        if (tmr_expired_i) begin
          if (csma_off) begin
            tx_d    = 1'b1;
            state_d = ST_TX;
          end else begin
            tmr_load_o = 1'b1;
            tmr_val_o  = TIMER_W'(rnd_first) * TIMER_W'(BO_PERIOD_US);
            state_d    = ST_BOFF;
          end
        end
      end
      ST_BOFF: begin
        if (tmr_expired_i) begin
          cca_d   = 1'b1;
          state_d = ST_CCA;
        end
      end
      ST_CCA: begin
        if (cca_done_i) begin
          if (cca_clear_i) begin
            tx_d    = 1'b1;
            state_d = ST_TX;
          end else if (nb_q == mcca_q) begin
            done_d   = 1'b1;
            status_d = STS_CSMA_FAIL;
            rx_d     = 1'b0;
            state_d  = ST_IDLE;
          end else begin
            nb_d       = nb_q + CCA_CNT_W'(1);
            be_d       = be_up;
            tmr_load_o = 1'b1;
            tmr_val_o  = TIMER_W'(rnd_next) * TIMER_W'(BO_PERIOD_US);
            state_d    = ST_BOFF;
          end
        end
      end
      ST_TX: begin
        if (tx_done_i) begin
          tries_d = tries_q + FRM_CNT_W'(1);
          if (!ackreq_q) begin
            done_d   = 1'b1;
            status_d = STS_OK;
            rx_d     = turn_q;
            state_d  = ST_IDLE;
          end else begin
            tmr_load_o = 1'b1;
            tmr_val_o  = TIMER_W'(ACK_WAIT_US);
            state_d    = ST_ACK;
          end
        end
      end
      ST_ACK: begin
        if (ack_match) begin
          done_d   = 1'b1;
          status_d = ack_pend_i ? STS_PEND : STS_OK;
          rx_d     = ack_pend_i | turn_q;
          state_d  = ST_IDLE;
        end else if (ack_valid_i || tmr_expired_i) begin
          if (tries_q == mfr_q) begin
            done_d   = 1'b1;
            status_d = STS_NOACK;
            rx_d     = 1'b0;
            state_d  = ST_IDLE;
          end else begin
            nb_d = '0;
            be_d = minbe_q;
            if (csma_off) begin
              tx_d    = 1'b1;
              state_d = ST_TX;
            end else begin
              tmr_load_o = 1'b1;
              tmr_val_o  = TIMER_W'(rnd_first) * TIMER_W'(BO_PERIOD_US);
              state_d    = ST_BOFF;
            end
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
    if (abort_i) begin
      state_d    = ST_IDLE;
      nb_d       = nb_q;
      be_d       = be_q;
      tries_d    = tries_q;
      cca_d      = 1'b0;
      tx_d       = 1'b0;
      done_d     = 1'b0;
      status_d   = status_q;
      rx_d       = rx_q;
      tmr_load_o = 1'b0;
      latch      = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      nb_q     <= '0;
      be_q     <= '0;
      tries_q  <= '0;
      cca_q    <= 1'b0;
      tx_q     <= 1'b0;
      done_q   <= 1'b0;
      status_q <= STS_OK;
      rx_q     <= 1'b0;
      mcca_q   <= '0;
      mfr_q    <= '0;
      minbe_q  <= '0;
      maxbe_q  <= '0;
      turn_q   <= 1'b0;
      ackreq_q <= 1'b0;
      seq_q    <= '0;
    end else begin
      state_q  <= state_d;
      nb_q     <= nb_d;
      be_q     <= be_d;
      tries_q  <= tries_d;
      cca_q    <= cca_d;
      tx_q     <= tx_d;
      done_q   <= done_d;
      status_q <= status_d;
      rx_q     <= rx_d;
      if (latch) begin
        mcca_q   <= cfg_max_cca_i;
        mfr_q    <= cfg_max_frame_i;
        minbe_q  <= cfg_min_be_i;
        maxbe_q  <= cfg_max_be_i;
        turn_q   <= cfg_turnaround_i;
        ackreq_q <= frm_ack_req_i;
        seq_q    <= frm_seq_i;
      end
    end
  end

  assign cca_start_o  = cca_q;
  assign tx_start_o   = tx_q;
  assign done_o       = done_q;
  assign status_o     = status_q;
  assign rx_after_o   = rx_q;
  assign ack_listen_o = (state_q == ST_ACK);
  assign busy_o       = (state_q != ST_IDLE);

  // R9
  done_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> status_q <= STS_CFG_ERR);
  // R9
  pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cca_q, tx_q, done_q}));
  // R4
  skip_no_cca_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cca_q |-> !csma_off);
  // R3
  be_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !csma_off) |-> be_q <= maxbe_q);
  // R10
  abort_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort_i |=> (!busy_o && !done_q && !cca_q && !tx_q));
  // R6
  ack_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ACK && ack_match && !abort_i) |=> (done_q && status_q <= STS_PEND));
endmodule

// File: rtl/csma_tx_ctrl.sv
module csma_tx_ctrl
  import csma_pkg::*;
#(
  parameter int          MAC_DELAY_US = 192,
  parameter int          BO_PERIOD_US = 320,
  parameter int          ACK_WAIT_US  = 864,
  parameter int          TIMER_W      = 20,
  parameter int          SEQ_W        = 8,
  parameter int          LFSR_W       = 16,
  parameter logic [15:0] LFSR_TAPS    = 16'hD008,
  parameter logic [15:0] LFSR_SEED    = 16'hACE1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             us_tick_i,
  input  logic             start_i,
  input  logic             abort_i,
  input  logic [2:0]       cfg_max_cca_i,
  input  logic [3:0]       cfg_max_frame_i,
  input  logic [3:0]       cfg_min_be_i,
  input  logic [3:0]       cfg_max_be_i,
  input  logic             cfg_turnaround_i,
  input  logic             frm_ack_req_i,
  input  logic [SEQ_W-1:0] frm_seq_i,
  input  logic             cca_done_i,
  input  logic             cca_clear_i,
  input  logic             tx_done_i,
  input  logic             ack_valid_i,
  input  logic [SEQ_W-1:0] ack_seq_i,
  input  logic             ack_pend_i,
  output logic             cca_start_o,
  output logic             tx_start_o,
  output logic             ack_listen_o,
  output logic             busy_o,
  output logic             done_o,
  output logic [2:0]       status_o,
  output logic             rx_after_o
);
  logic [RND_W-1:0]   rnd;
  logic               tmr_load, tmr_expired;
  logic [TIMER_W-1:0] tmr_val;

  csma_lfsr #(
    .W(LFSR_W), .OUT_W(RND_W), .TAPS(LFSR_TAPS), .SEED(LFSR_SEED)
  ) lfsr_i (
    .clk(clk), .rst_n(rst_n), .rnd_o(rnd)
  );

  csma_tick_timer #(.W(TIMER_W)) tmr_i (
    .clk(clk), .rst_n(rst_n), .tick_i(us_tick_i), .load_i(tmr_load),
    .val_i(tmr_val), .expired_o(tmr_expired)
  );

  csma_seq #(
    .MAC_DELAY_US(MAC_DELAY_US), .BO_PERIOD_US(BO_PERIOD_US),
    .ACK_WAIT_US(ACK_WAIT_US), .TIMER_W(TIMER_W), .SEQ_W(SEQ_W)
  ) seq_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .abort_i(abort_i),
    .cfg_max_cca_i(cfg_max_cca_i), .cfg_max_frame_i(cfg_max_frame_i),
    .cfg_min_be_i(cfg_min_be_i), .cfg_max_be_i(cfg_max_be_i),
    .cfg_turnaround_i(cfg_turnaround_i), .frm_ack_req_i(frm_ack_req_i),
    .frm_seq_i(frm_seq_i), .cca_done_i(cca_done_i), .cca_clear_i(cca_clear_i),
    .tx_done_i(tx_done_i), .ack_valid_i(ack_valid_i), .ack_seq_i(ack_seq_i),
    .ack_pend_i(ack_pend_i), .rnd_i(rnd), .tmr_expired_i(tmr_expired),
    .tmr_load_o(tmr_load), .tmr_val_o(tmr_val), .cca_start_o(cca_start_o),
    .tx_start_o(tx_start_o), .ack_listen_o(ack_listen_o), .busy_o(busy_o),
    .done_o(done_o), .status_o(status_o), .rx_after_o(rx_after_o)
  );
endmodule

// File: tb/csma_tx_ctrl_tb_top.sv
`timescale 1ns/1ps
module csma_tx_ctrl_tb_top;
  localparam int MAC = 6;
  localparam int BOP = 3;
  localparam int ACKW = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic us_tick = 1'b1, start = 1'b0, abort = 1'b0;
  logic [2:0] c_cca = '0;
  logic [3:0] c_frm = '0, c_minbe = '0, c_maxbe = '0;
  logic c_turn = 1'b0, f_ackreq = 1'b0;
  logic [7:0] f_seq = 8'h5A;
  logic cca_done = 1'b0, cca_clear = 1'b0, tx_done = 1'b0, ack_valid = 1'b0, ack_pend = 1'b0;
  logic [7:0] ack_seq = '0;
  logic cca_start, tx_start, ack_listen, busy, done, rx_after;
  logic [2:0] status;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  csma_tx_ctrl #(.MAC_DELAY_US(MAC), .BO_PERIOD_US(BOP), .ACK_WAIT_US(ACKW)) dut_i (
    .clk(clk), .rst_n(rst_n), .us_tick_i(us_tick), .start_i(start), .abort_i(abort),
    .cfg_max_cca_i(c_cca), .cfg_max_frame_i(c_frm), .cfg_min_be_i(c_minbe),
    .cfg_max_be_i(c_maxbe), .cfg_turnaround_i(c_turn), .frm_ack_req_i(f_ackreq),
    .frm_seq_i(f_seq), .cca_done_i(cca_done), .cca_clear_i(cca_clear),
    .tx_done_i(tx_done), .ack_valid_i(ack_valid), .ack_seq_i(ack_seq),
    .ack_pend_i(ack_pend), .cca_start_o(cca_start), .tx_start_o(tx_start),
    .ack_listen_o(ack_listen), .busy_o(busy), .done_o(done), .status_o(status),
    .rx_after_o(rx_after)
  );

  typedef struct packed {
    logic [3:0] req;
    logic [2:0] mcca;
    logic [3:0] mfr;
    logic [3:0] minbe;
    logic [3:0] maxbe;
    logic       turn;
    logic       ackreq;
    logic [3:0] busy_n;
    logic [1:0] mode;   // 0 no ACK, 1 match, 2 wrong seq, 3 match + pending
    logic [7:0] dly;
    logic [2:0] ex_sts;
    logic [3:0] ex_cca;
    logic [3:0] ex_tx;
    logic       ex_rx;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VECS [NV] = '{
    '{4'd5, 3'd4, 4'd3, 4'd3, 4'd5, 1'b0, 1'b0, 4'd0, 2'd0, 8'd2,  3'd0, 4'd0+4'd1, 4'd1, 1'b0}, // R5
    '{4'd5, 3'd4, 4'd3, 4'd3, 4'd5, 1'b1, 1'b0, 4'd0, 2'd0, 8'd2,  3'd0, 4'd1, 4'd1, 1'b1},      // R5
    '{4'd6, 3'd4, 4'd3, 4'd3, 4'd5, 1'b0, 1'b1, 4'd0, 2'd1, 8'd2,  3'd0, 4'd1, 4'd1, 1'b0},      // R6
    '{4'd6, 3'd4, 4'd3, 4'd3, 4'd5, 1'b0, 1'b1, 4'd0, 2'd3, 8'd2,  3'd1, 4'd1, 4'd1, 1'b1},      // R6
    '{4'd6, 3'd4, 4'd3, 4'd3, 4'd5, 1'b1, 1'b1, 4'd0, 2'd1, 8'd15, 3'd0, 4'd1, 4'd1, 1'b1},      // R6
    '{4'd3, 3'd2, 4'd3, 4'd3, 4'd5, 1'b0, 1'b0, 4'd9, 2'd0, 8'd2,  3'd2, 4'd3, 4'd0, 1'b0},      // R3
    '{4'd3, 3'd0, 4'd3, 4'd3, 4'd5, 1'b0, 1'b0, 4'd1, 2'd0, 8'd2,  3'd2, 4'd1, 4'd0, 1'b0},      // R3
    '{4'd3, 3'd4, 4'd3, 4'd2, 4'd3, 1'b0, 1'b0, 4'd2, 2'd0, 8'd2,  3'd0, 4'd3, 4'd1, 1'b0},      // R3
    '{4'd7, 3'd4, 4'd3, 4'd3, 4'd5, 1'b0, 1'b1, 4'd0, 2'd0, 8'd2,  3'd3, 4'd3, 4'd3, 1'b0},      // R7
    '{4'd7, 3'd4, 4'd2, 4'd3, 4'd5, 1'b0, 1'b1, 4'd0, 2'd2, 8'd2,  3'd3, 4'd2, 4'd2, 1'b0},      // R7
    '{4'd7, 3'd4, 4'd1, 4'd3, 4'd5, 1'b0, 1'b1, 4'd0, 2'd1, 8'd40, 3'd3, 4'd1, 4'd1, 1'b0},      // R7
    '{4'd4, 3'd7, 4'd3, 4'd3, 4'd5, 1'b0, 1'b0, 4'd0, 2'd0, 8'd2,  3'd0, 4'd0, 4'd1, 1'b0},      // R4
    '{4'd4, 3'd7, 4'd2, 4'd3, 4'd5, 1'b0, 1'b1, 4'd0, 2'd0, 8'd2,  3'd3, 4'd0, 4'd2, 1'b0},      // R4
    '{4'd4, 3'd7, 4'd3, 4'd9, 4'd15,1'b1, 1'b0, 4'd0, 2'd0, 8'd2,  3'd0, 4'd0, 4'd1, 1'b1},      // R4
    '{4'd8, 3'd6, 4'd3, 4'd3, 4'd5, 1'b0, 1'b0, 4'd0, 2'd0, 8'd2,  3'd4, 4'd0, 4'd0, 1'b0},      // R8
    '{4'd8, 3'd4, 4'd3, 4'd6, 4'd4, 1'b0, 1'b0, 4'd0, 2'd0, 8'd2,  3'd4, 4'd0, 4'd0, 1'b0},      // R8
    '{4'd8, 3'd4, 4'd3, 4'd3, 4'd9, 1'b0, 1'b0, 4'd0, 2'd0, 8'd2,  3'd4, 4'd0, 4'd0, 1'b0},      // R8
    '{4'd8, 3'd4, 4'd0, 4'd3, 4'd5, 1'b0, 1'b0, 4'd0, 2'd0, 8'd2,  3'd4, 4'd0, 4'd0, 1'b0}       // R8
  };

  task automatic check(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic set_cfg(input vec_t v);
    c_cca = v.mcca; c_frm = v.mfr; c_minbe = v.minbe; c_maxbe = v.maxbe;
    c_turn = v.turn; f_ackreq = v.ackreq;
  endtask

  task automatic run_txn(input vec_t v, output int sts, output int rxa,
                         output int ncca, output int ntx, output int ndone);
    int cd_cca, cd_tx, cd_ack, busy_left;
    bit armed;
    cd_cca = 0; cd_tx = 0; cd_ack = 0; busy_left = v.busy_n; armed = 0;
    sts = -1; rxa = -1; ncca = 0; ntx = 0; ndone = 0;
    set_cfg(v);
    @(negedge clk); start = 1'b1;
    for (int cyc = 0; cyc < 4000; cyc++) begin
      @(negedge clk);
      start = 1'b0; cca_done = 1'b0; tx_done = 1'b0; ack_valid = 1'b0;
      if (cd_cca > 0) begin
        cd_cca--;
        if (cd_cca == 0) begin
          cca_done = 1'b1; cca_clear = (busy_left == 0);
          if (busy_left > 0) busy_left--;
        end
      end
      if (cd_tx > 0) begin
        cd_tx--;
        if (cd_tx == 0) begin tx_done = 1'b1; busy_left = v.busy_n; end
      end
      if (cd_ack > 0) begin
        cd_ack--;
        if (cd_ack == 0) begin
          ack_valid = 1'b1;
          ack_seq   = (v.mode == 2'd2) ? f_seq + 8'd1 : f_seq;
          ack_pend  = (v.mode == 2'd3);
        end
      end
      if (done) begin ndone = 1; sts = status; rxa = rx_after; break; end
      if (cca_start) begin ncca++; cd_cca = 2; end
      if (tx_start) begin ntx++; cd_tx = 3; armed = 0; end
      if (ack_listen && !armed && v.mode != 2'd0) begin armed = 1; cd_ack = v.dly; end
    end
    @(negedge clk);
    cca_done = 1'b0; tx_done = 1'b0; ack_valid = 1'b0; ack_pend = 1'b0;
    if (done) ndone++;
  endtask

  // cycles (negedges) from command to first CCA request; leaves block running
  task automatic first_cca(input vec_t v, output int k);
    set_cfg(v);
    k = -1;
    @(negedge clk); start = 1'b1;
    for (int i = 1; i < 600; i++) begin
      @(negedge clk); start = 1'b0;
      if (cca_start) begin k = i; break; end
    end
  endtask

  task automatic abort_and_watch(input string req);
    int bad;
    bad = 0;
    @(negedge clk); abort = 1'b1;
    @(negedge clk); abort = 1'b0;
    for (int i = 0; i < 60; i++) begin
      if (done || tx_start || cca_start || busy) bad++;
      @(negedge clk);
    end
    check(req, "activity after abort", bad, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int sts, rxa, ncca, ntx, ndone, k, bad;
    vec_t v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1", "busy", busy, 0);
    check("R1", "done", done, 0);
    check("R1", "cca/tx/listen", {cca_start, tx_start, ack_listen}, 0);
    check("R1", "status", status, 0);

    for (int i = 0; i < NV; i++) begin
      run_txn(VECS[i], sts, rxa, ncca, ntx, ndone);
      check($sformatf("R%0d", VECS[i].req), $sformatf("v%0d status", i), sts, VECS[i].ex_sts);
      check($sformatf("R%0d", VECS[i].req), $sformatf("v%0d cca count", i), ncca, VECS[i].ex_cca);
      check($sformatf("R%0d", VECS[i].req), $sformatf("v%0d tx count", i), ntx, VECS[i].ex_tx);
      check($sformatf("R%0d", VECS[i].req), $sformatf("v%0d rx_after", i), rxa, VECS[i].ex_rx);
      check("R9", $sformatf("v%0d single done pulse", i), ndone, 1);
      check("R9", $sformatf("v%0d idle after", i), busy, 0);
    end

    // R2: minimum exponent 0 forces zero backoff: exact MAC delay timing
    v = VECS[0]; v.minbe = 4'd0; v.maxbe = 4'd3;
    first_cca(v, k);
    check("R2", "first CCA cycle with BE 0", k, MAC + 3);
    // R10 abort while waiting for the CCA result
    abort_and_watch("R10");

    // R2: backoff bounded by (2^3-1) periods at fixed exponent 3
    v.minbe = 4'd3; v.maxbe = 4'd3;
    for (int r = 0; r < 6; r++) begin
      first_cca(v, k);
      check("R2", $sformatf("backoff run %0d in range", r),
            int'(k >= MAC + 3 && k <= MAC + 3 + 7 * BOP), 1);
      abort_and_watch("R10");
    end

    // R2: waits advance only on ticks
    us_tick = 1'b0;
    set_cfg(v);
    @(negedge clk); start = 1'b1;
    bad = 0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk); start = 1'b0;
      if (cca_start || tx_start || !busy) bad++;
    end
    check("R2", "no progress without tick", bad, 0);
    us_tick = 1'b1;
    k = -1;
    for (int i = 1; i < 200; i++) begin
      @(negedge clk);
      if (cca_start) begin k = i; break; end
    end
    check("R2", "progress after tick resumes", int'(k >= MAC + 1 && k <= MAC + 2 + 7 * BOP), 1);
    abort_and_watch("R10");

    // R10: abort beats a command in the same cycle
    set_cfg(VECS[0]);
    @(negedge clk); start = 1'b1; abort = 1'b1;
    @(negedge clk); start = 1'b0; abort = 1'b0;
    bad = 0;
    for (int i = 0; i < 20; i++) begin
      if (busy || done || cca_start || tx_start) bad++;
      @(negedge clk);
    end
    check("R10", "abort with start", bad, 0);

    // R11: stray strobes while idle change nothing
    @(negedge clk); cca_done = 1'b1; cca_clear = 1'b1; tx_done = 1'b1;
    ack_valid = 1'b1; ack_seq = f_seq;
    @(negedge clk); cca_done = 1'b0; tx_done = 1'b0; ack_valid = 1'b0;
    bad = 0;
    for (int i = 0; i < 20; i++) begin
      if (busy || done || cca_start || tx_start || ack_listen) bad++;
      @(negedge clk);
    end
    check("R11", "stray strobes while idle", bad, 0);
    check("R11", "status kept", status, VECS[NV-1].ex_sts);

    // block still usable after aborts
    run_txn(VECS[2], sts, rxa, ncca, ntx, ndone);
    check("R10", "run after abort status", sts, 0);
    check("R10", "run after abort done", ndone, 1);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule